// File: doc/BRIEF.md
# Self-Synchronizing Line Scrambler Pair

This block whitens the serial bit stream of a 2B1Q line framer. It has a transmit lane that scrambles outgoing bits and a receive lane that descrambles incoming bits. Both lanes are built on a 23-stage shift register. Because the receive side is self-synchronizing, it needs no seed exchange. After 23 correctly received bits its register holds the same contents as the far-end scrambler, and its output is clean from then on.

A parameter selects the link direction. The direction picks the short feedback tap: delay 5 for traffic from the network to the terminal (downlink), and delay 18 for traffic from the terminal to the network (uplink). The long tap always sits at delay 23.

Each lane has a per-bit bypass input. The framer raises it on sync-word bits, which then cross the lane unchanged and do not advance the register. The receive lane only works while the framer reports frame lock. Each lane accepts one bit per cycle under a valid strobe and presents its result one cycle later with its own valid strobe.

Top module: `lineScrambler`

## Requirements
- R1: A synchronous reset clears both shift registers to all zeros and drops both output valids. Right after reset, a run of zero bits scrambles to zero bits.
- R2: A bit accepted in a cycle, meaning its input valid is 1 and, on the receive lane, lock is 1, appears on the lane output with the lane's output valid set to 1 exactly one clock later. No output valid is raised otherwise.
- R3: An accepted bit with bypass set to 1 is presented at the lane output unchanged.
- R4: A bypassed bit does not shift the register on either lane. Scrambling and descrambling of the following bits continue as if the bypassed bit had not been there.
- R5: With the downlink direction, each non-bypassed transmit bit is output as input XOR the register bit at delay 5 XOR the register bit at delay 23, and that output bit is shifted into the register.
- R6: The receive lane shifts each received non-bypassed bit into its register and outputs it XORed with the same two taps, so it restores the original stream from the scrambled one.
- R7: Starting from any register contents, the receive lane output matches the original stream from the 24th correctly received bit onward.
- R8: A single flipped line bit at position n produces output errors exactly at positions n, n+5 and n+23 on the downlink direction, and nowhere else.
- R9: While lock is 0, received bits are dropped: there is no output valid and the receive register holds its state.
- R10: Cycles with input valid at 0 leave the register and the output stream unaffected.
- R11: With the uplink direction, the short tap is at delay 18 in place of 5. The long tap stays at delay 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txInValid | input | 1 | Transmit input bit valid |
| txInBit | input | 1 | Transmit input bit |
| txBypass | input | 1 | Pass the current transmit bit unscrambled (sync word) |
| txOutValid | output | 1 | Transmit output bit valid |
| txOutBit | output | 1 | Scrambled line bit |
| rxInValid | input | 1 | Receive input bit valid |
| rxInBit | input | 1 | Received line bit |
| rxBypass | input | 1 | Pass the current receive bit undescrambled (sync word) |
| rxLocked | input | 1 | Framer reports frame lock; the receive lane runs only while high |
| rxOutValid | output | 1 | Receive output bit valid |
| rxOutBit | output | 1 | Descrambled bit |

## Verification
The hardest state to reach is a receive register that disagrees with the far-end scrambler, because after reset both lanes start from the same all-zero contents. The bench reaches it by feeding the receive lane a burst of random bits while lock is high. It then follows with a freshly scrambled stream and checks that only the first 23 outputs may differ. The bench also scrambles a stream, flips one line bit before descrambling it, and compares the error positions against the three expected offsets. Lock gaps and bypass positions are placed in the middle of a loopback stream, so any register movement they cause shows up as a corrupted output later in that stream.

// File: rtl/lineScrPkg.sv
package lineScrPkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } linkDirT;

  typedef struct packed {
    logic emit;
    logic advance;
    logic pass;
  } scrStrobeT;

endpackage

// File: rtl/scrCtrl.sv
module scrCtrl
  import lineScrPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      bypass,
  input  logic      enable,
  output scrStrobeT strobe,
  output logic      outValid
);

  always_comb begin
    strobe.emit    = inValid & enable;
    strobe.advance = inValid & enable & ~bypass;
    strobe.pass    = bypass;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobe.emit;
  end

  // R2: an accepted bit produces an output valid in the next cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (inValid && enable) |=> outValid);

  // R9: no output while the lane is disabled (receive lane unlocked)
  a_r9_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !outValid);

endmodule

// File: rtl/scrPath.sv
module scrPath
  import lineScrPkg::*;
#(
  parameter int REG_LEN    = 23,
  parameter int SHORT_TAP  = 5,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  scrStrobeT strobe,
  input  logic      inBit,
  output logic      outBit
);

  localparam int LONG_IDX  = REG_LEN - 1;
  localparam int SHORT_IDX = SHORT_TAP - 1;

  logic [REG_LEN-1:0] shiftReg;
  logic               tapXor;
  logic               mixed;
  logic               feedBit;

  assign tapXor = shiftReg[SHORT_IDX] ^ shiftReg[LONG_IDX];
  assign mixed  = inBit ^ tapXor;

  generate
    if (DESCRAMBLE) begin : gFeedLine
      assign feedBit = inBit;
    end else begin : gFeedOut
      assign feedBit = mixed;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
    end else begin
      if (strobe.advance) shiftReg <= {shiftReg[REG_LEN-2:0], feedBit};
      if (strobe.emit)    outBit   <= strobe.pass ? inBit : mixed;
    end
  end

  // R3: a bypassed bit leaves the lane untouched
  a_r3_bypass_raw: assert property (@(posedge clk) disable iff (rst)
    (strobe.emit && strobe.pass) |=> (outBit == $past(inBit)));

  // R4: a bypassed bit does not move the register
  a_r4_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe.emit && strobe.pass) |=> $stable(shiftReg));

  // R10 / R9: no accepted bit, no register movement
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.emit |=> $stable(shiftReg));

endmodule

// File: rtl/lineScrambler.sv
module lineScrambler
  import lineScrPkg::*;
#(
  parameter int      REG_LEN  = 23,
  parameter int      DOWN_TAP = 5,
  parameter int      UP_TAP   = 18,
  parameter linkDirT LINK_DIR = DIR_DOWN
) (
  input  logic clk,
  input  logic rst,
  input  logic txInValid,
  input  logic txInBit,
  input  logic txBypass,
  output logic txOutValid,
  output logic txOutBit,
  input  logic rxInValid,
  input  logic rxInBit,
  input  logic rxBypass,
  input  logic rxLocked,
  output logic rxOutValid,
  output logic rxOutBit
);

  localparam int SHORT_TAP = (LINK_DIR == DIR_DOWN) ? DOWN_TAP : UP_TAP;

  scrStrobeT txStrobe;
  scrStrobeT rxStrobe;

  scrCtrl txCtrl (
    .clk(clk), .rst(rst), .inValid(txInValid), .bypass(txBypass),
    .enable(1'b1), .strobe(txStrobe), .outValid(txOutValid)
  );

  scrPath #(.REG_LEN(REG_LEN), .SHORT_TAP(SHORT_TAP), .DESCRAMBLE(1'b0)) txPath (
    .clk(clk), .rst(rst), .strobe(txStrobe), .inBit(txInBit), .outBit(txOutBit)
  );

  scrCtrl rxCtrl (
    .clk(clk), .rst(rst), .inValid(rxInValid), .bypass(rxBypass),
    .enable(rxLocked), .strobe(rxStrobe), .outValid(rxOutValid)
  );

  scrPath #(.REG_LEN(REG_LEN), .SHORT_TAP(SHORT_TAP), .DESCRAMBLE(1'b1)) rxPath (
    .clk(clk), .rst(rst), .strobe(rxStrobe), .inBit(rxInBit), .outBit(rxOutBit)
  );

endmodule

// File: tb/lineScrambler_test.sv
`timescale 1ns/1ps
module lineScrambler_test;
  import lineScrPkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic txInValid = 0, txInBit = 0, txBypass = 0;
  logic rxInValid = 0, rxInBit = 0, rxBypass = 0, rxLocked = 0;
  logic txOutValid, txOutBit, rxOutValid, rxOutBit;
  logic upOutValid, upOutBit, upRxValid, upRxBit;

  lineScrambler uut (
    .clk(clk), .rst(rst),
    .txInValid(txInValid), .txInBit(txInBit), .txBypass(txBypass),
    .txOutValid(txOutValid), .txOutBit(txOutBit),
    .rxInValid(rxInValid), .rxInBit(rxInBit), .rxBypass(rxBypass),
    .rxLocked(rxLocked), .rxOutValid(rxOutValid), .rxOutBit(rxOutBit)
  );

  lineScrambler #(.LINK_DIR(DIR_UP)) uutUp (
    .clk(clk), .rst(rst),
    .txInValid(txInValid), .txInBit(txInBit), .txBypass(txBypass),
    .txOutValid(upOutValid), .txOutBit(upOutBit),
    .rxInValid(1'b0), .rxInBit(1'b0), .rxBypass(1'b0),
    .rxLocked(1'b0), .rxOutValid(upRxValid), .rxOutBit(upRxBit)
  );

  typedef struct {
    logic  b;
    string req;
  } expT;

  expT  txQ[$], upQ[$], rxQ[$];
  logic rxSeen[$];
  logic origBits[$];
  logic scrList[$];
  logic byMask[$];
  logic [22:0] mDown = '0, mUp = '0, mRx = '0;
  int nRun = 0, nFail = 0;

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // monitor: pops expectations as outputs appear
  always @(negedge clk) begin
    expT e;
    if (!rst) begin
      if (txOutValid) begin
        if (txQ.size() == 0) check("R2 extra downlink tx output", 1'b1, 1'b0);
        else begin e = txQ.pop_front(); check(e.req, txOutBit, e.b); end
      end
      if (upOutValid) begin
        if (upQ.size() == 0) check("R2 extra uplink tx output", 1'b1, 1'b0);
        else begin e = upQ.pop_front(); check(e.req, upOutBit, e.b); end
      end
      if (upRxValid) check("R9 uplink rx must stay idle", 1'b1, 1'b0);
      if (rxOutValid) begin
        rxSeen.push_back(rxOutBit);
        if (rxQ.size() == 0) check("R2/R9 extra rx output", 1'b1, 1'b0);
        else begin e = rxQ.pop_front(); check(e.req, rxOutBit, e.b); end
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes expectations
  task automatic drive(input logic tv, input logic tb, input logic tbyp,
                       input logic rv, input logic rb, input logic rbyp,
                       input logic lk, input string req);
    expT  e;
    logic o;
    @(negedge clk);
    txInValid = tv; txInBit = tb; txBypass = tbyp;
    rxInValid = rv; rxInBit = rb; rxBypass = rbyp; rxLocked = lk;
    if (tv) begin
      if (tbyp) o = tb;
      else begin o = tb ^ mDown[4] ^ mDown[22]; mDown = {mDown[21:0], o}; end
      e.b = o; e.req = {req, " (R5 downlink)"}; txQ.push_back(e);
      scrList.push_back(o);
      if (tbyp) o = tb;
      else begin o = tb ^ mUp[17] ^ mUp[22]; mUp = {mUp[21:0], o}; end
      e.b = o; e.req = {req, " (R11 uplink)"}; upQ.push_back(e);
    end
    if (rv && lk) begin
      if (rbyp) o = rb;
      else begin o = rb ^ mRx[4] ^ mRx[22]; mRx = {mRx[21:0], rb}; end
      e.b = o; e.req = {req, " (rx)"}; rxQ.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 1, "idle");
  endtask

  task automatic doReset();
    idle(3);
    @(negedge clk);
    rst = 1'b1;
    mDown = '0; mUp = '0; mRx = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tx valid low after reset", txOutValid, 1'b0);
    check("R1 rx valid low after reset", rxOutValid, 1'b0);
  endtask

  task automatic makeOrig(input int n);
    origBits.delete();
    for (int i = 0; i < n; i++) origBits.push_back(logic'($urandom % 2));
  endtask

  task automatic compareSeen(input string req);
    check({req, " output count"}, logic'(rxSeen.size() == origBits.size()), 1'b1);
    for (int i = 0; i < origBits.size() && i < rxSeen.size(); i++)
      check(req, rxSeen[i], origBits[i]);
  endtask

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int errCount;
    logic isErr, wantErr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    doReset();

    // R1: zeros from the all-zero state stay zero
    for (int i = 0; i < 30; i++) drive(1, 0, 0, 1, 0, 0, 1, "R1 zero state");

    // R5 / R11: random transmit stream
    for (int i = 0; i < 150; i++) drive(1, logic'($urandom % 2), 0, 0, 0, 0, 1, "R5 R11 stream");

    // R3 / R4: bypass positions interleaved
    for (int i = 0; i < 120; i++)
      drive(1, logic'($urandom % 2), logic'(i % 7 == 3), 0, 0, 0, 1, "R3 R4 bypass");

    // R10: idle cycles scattered through the stream
    for (int i = 0; i < 100; i++)
      drive(logic'($urandom % 2), logic'($urandom % 2), 0, 0, 0, 0, 1, "R10 gaps");

    // R6: loopback restores the original stream
    doReset();
    makeOrig(100); scrList.delete();
    foreach (origBits[i]) drive(1, origBits[i], 0, 0, 0, 0, 1, "R6 tx side");
    idle(3); rxSeen.delete();
    foreach (scrList[i]) drive(0, 0, 0, 1, scrList[i], 0, 1, "R6 rx side");
    idle(3);
    compareSeen("R6 loopback");

    // R9: unlocked garbage in the middle is dropped and the register holds
    doReset(); rxSeen.delete();
    for (int i = 0; i < 50; i++) drive(0, 0, 0, 1, scrList[i], 0, 1, "R9 before gap");
    for (int i = 0; i < 15; i++) drive(0, 0, 0, 1, logic'($urandom % 2), 0, 0, "R9 unlocked");
    for (int i = 50; i < 100; i++) drive(0, 0, 0, 1, scrList[i], 0, 1, "R9 after gap");
    idle(3);
    compareSeen("R9 unlocked gap");

    // R4: bypass on both lanes at matching positions
    doReset();
    makeOrig(80); scrList.delete(); byMask.delete();
    foreach (origBits[i]) begin
      byMask.push_back(logic'(i % 9 == 0));
      drive(1, origBits[i], byMask[i], 0, 0, 0, 1, "R4 tx bypass");
    end
    idle(3); rxSeen.delete();
    foreach (scrList[i]) drive(0, 0, 0, 1, scrList[i], byMask[i], 1, "R4 rx bypass");
    idle(3);
    compareSeen("R4 bypass loopback");

    // R7: receiver starts misaligned and recovers after 23 bits
    doReset();
    makeOrig(80); scrList.delete();
    foreach (origBits[i]) drive(1, origBits[i], 0, 0, 0, 0, 1, "R7 tx side");
    for (int i = 0; i < 40; i++) drive(0, 0, 0, 1, logic'($urandom % 2), 0, 1, "R7 garbage");
    idle(3); rxSeen.delete();
    foreach (scrList[i]) drive(0, 0, 0, 1, scrList[i], 0, 1, "R7 rx side");
    idle(3);
    errCount = 0;
    for (int i = 23; i < rxSeen.size(); i++) if (rxSeen[i] !== origBits[i]) errCount++;
    check("R7 bits after 23 all clean", logic'(errCount == 0), 1'b1);
    check("R7 output count", logic'(rxSeen.size() == 80), 1'b1);

    // R8: single line error multiplies to positions n, n+5, n+23
    doReset();
    makeOrig(80); scrList.delete();
    foreach (origBits[i]) drive(1, origBits[i], 0, 0, 0, 0, 1, "R8 tx side");
    idle(3); rxSeen.delete();
    foreach (scrList[i]) drive(0, 0, 0, 1, scrList[i] ^ logic'(i == 10), 0, 1, "R8 rx side");
    idle(3);
    check("R8 output count", logic'(rxSeen.size() == 80), 1'b1);
    for (int i = 0; i < 80 && i < rxSeen.size(); i++) begin
      isErr   = logic'(rxSeen[i] !== origBits[i]);
      wantErr = logic'(i == 10 || i == 15 || i == 33);
      check("R8 error position", isErr, wantErr);
    end

    idle(4);
    check("R2 no missing tx outputs", logic'(txQ.size() == 0), 1'b1);
    check("R2 no missing uplink outputs", logic'(upQ.size() == 0), 1'b1);
    check("R2 no missing rx outputs", logic'(rxQ.size() == 0), 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule